// File: doc/BRIEF.md
# Serial EEPROM Transaction Sequencer

This block turns a single EEPROM request into the command words that an I2C master command queue executes. A request carries an 8-bit device address, a 16-bit memory address, a byte count and a direction. The sequencer forms the 7-bit target address. For a write, it pushes the memory address and the payload from a byte stream as one transfer. For a read, it first sets the memory pointer with a two-byte write and then reads the requested bytes through a repeated START. At the end it reports a bit-flag error code with a one-cycle done pulse.

Read bytes leave in order on a valid/ready stream. After a successful write, the block waits out the EEPROM internal write cycle before it accepts the next request. Two waits are bounded by a millisecond limit: waiting for the queue to drain, and waiting for receive data. Both limits are counted by a prescaler that divides the clock down to millisecond ticks.

Top module: `eeprom_seq`

## Requirements
- R1: `tgt_addr` equals bits [7:1] of the request's device address and stays stable from acceptance until the next request.
- R2: A write pushes, in order, memory address bits [15:8], bits [7:0], then `req_len+1` bytes taken from the write stream. Every entry has `cmd_rd=0` and `cmd_restart=0`, and `cmd_stop=1` appears only on the final entry. While `req_ready` is high, no command, write-stream or read-stream handshake is offered.
- R3: After a write whose queue drains with no error, `done` arrives WRCYC_MS milliseconds (WRCYC_MS·CLK_KHZ cycles, plus a few cycles) after the last entry is accepted.
- R4: A read pushes the two memory-address bytes with `cmd_stop=0` and `cmd_restart=0`. After the queue drains it pushes `req_len+1` entries with `cmd_rd=1`, `cmd_restart=1` only on the first entry and `cmd_stop=1` only on the last. Each read entry is pushed only after the previous byte has been delivered.
- R5: Read bytes appear on `rd_data` in arrival order. While `rd_ready` is low, `rd_valid` and `rd_data` hold.
- R6: When the queue drains, the error code is built as follows. With an abort present, data NACK gives 2, otherwise address NACK gives 1, otherwise the code is 0x10. Bus timeout ORs in 4. A clean transfer gives 0.
- R7: If a command push stalls, the queue fails to drain, or receive data is missing for WAIT_MS milliseconds, the sequence ends with code 8.
- R8: Any nonzero code from the address phase or the write transfer ends the request at once. No read entries are pushed and no write-cycle wait is spent.
- R9: After reset, `req_ready=1` and `cmd_valid`, `rd_valid` and `done` are 0. `done` is a single-cycle pulse and `err` holds the code during it.
- R10: While waiting for a read byte, an abort flagged as address NACK ends the request with code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_dev | input | 8 | 8-bit device address |
| req_mem | input | 16 | EEPROM memory address |
| req_len | input | LEN_W | Byte count minus one |
| req_read | input | 1 | 1 = read, 0 = write |
| wr_valid | input | 1 | Write payload byte offered |
| wr_ready | output | 1 | Write payload byte taken |
| wr_data | input | 8 | Write payload byte |
| cmd_valid | output | 1 | Command entry offered to the master queue |
| cmd_ready | input | 1 | Queue accepts entry |
| cmd_data | output | 8 | Entry data byte |
| cmd_rd | output | 1 | Entry is a read |
| cmd_stop | output | 1 | STOP after this entry |
| cmd_restart | output | 1 | Repeated START before this entry |
| tgt_addr | output | 7 | 7-bit target address |
| txq_empty | input | 1 | Master transmit queue empty |
| mst_abort | input | 1 | Master aborted the transfer |
| mst_addr_nack | input | 1 | Abort cause: address not acknowledged |
| mst_data_nack | input | 1 | Abort cause: data not acknowledged |
| mst_bus_tmo | input | 1 | Master bus timeout |
| rx_valid | input | 1 | Received byte available |
| rx_ready | output | 1 | Received byte consumed |
| rx_data | input | 8 | Received byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Request finished (pulse) |
| err | output | 5 | Error flags |

## Verification
The bench builds the block with CLK_KHZ=4 and LEN_W=3. At these values a millisecond lasts four cycles, so both the 20 ms limit and the 10 ms write-cycle wait finish within about a hundred cycles and their exact cycle windows can be checked. Every legal length from 1 to 8 bytes is swept in both directions. The abort-cause combinations, a stalled queue, a missing receive byte and an address NACK arriving mid-read are all driven within a short run.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_PUSH_W, S_DRAIN, S_PUSH_R, S_RX_WAIT, S_POST, S_DONE
    } seq_state_e;

    typedef struct packed {
        logic       restart;
        logic       stop;
        logic       rd;
        logic [7:0] data;
    } cmd_word_t;

    typedef struct packed {
        logic abort;
        logic addr_nack;
        logic data_nack;
        logic bus_tmo;
    } mst_stat_t;

    localparam logic [4:0] ERR_OK        = 5'h00;
    localparam logic [4:0] ERR_ADDR_NACK = 5'h01;
    localparam logic [4:0] ERR_DATA_NACK = 5'h02;
    localparam logic [4:0] ERR_BUS_TMO   = 5'h04;
    localparam logic [4:0] ERR_WAIT_TMO  = 5'h08;
    localparam logic [4:0] ERR_OTHER     = 5'h10;

    // data NACK outranks address NACK; an unexplained abort is "other"
    function automatic logic [4:0] abort_code(mst_stat_t s);
        logic [4:0] c;
        c = ERR_OK;
        if (s.abort) begin
            if (s.data_nack)      c = ERR_DATA_NACK;
            else if (s.addr_nack) c = ERR_ADDR_NACK;
            else                  c = ERR_OTHER;
        end
        if (s.bus_tmo) c = c | ERR_BUS_TMO;
        return c;
    endfunction

endpackage

// File: rtl/eeseq_mstimer.sv
module eeseq_mstimer #(
    parameter int TICK_CYC = 100000,
    parameter int MS_W     = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    output logic [MS_W-1:0] ms
);
    localparam int PRE_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_CYC - 1);

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (pre_q == PRE_TOP) begin
            pre_q <= '0;
            if (ms_q != '1) ms_q <= ms_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign ms = ms_q;
endmodule

// File: rtl/eeseq_errmap.sv
module eeseq_errmap
    import eeseq_pkg::*;
(
    input  mst_stat_t  stat,
    output logic [4:0] code
);
    assign code = abort_code(stat);
endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
    import eeseq_pkg::*;
#(
    parameter int CLK_KHZ  = 100000,
    parameter int WAIT_MS  = 20,
    parameter int WRCYC_MS = 10,
    parameter int LEN_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_dev,
    input  logic [15:0]      req_mem,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_read,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [7:0]       cmd_data,
    output logic             cmd_rd,
    output logic             cmd_stop,
    output logic             cmd_restart,
    output logic [6:0]       tgt_addr,
    input  logic             txq_empty,
    input  logic             mst_abort,
    input  logic             mst_addr_nack,
    input  logic             mst_data_nack,
    input  logic             mst_bus_tmo,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [7:0]       rx_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic [4:0]       err
);
    localparam int MS_MAX = (WAIT_MS > WRCYC_MS) ? WAIT_MS : WRCYC_MS;
    localparam int MS_W   = $clog2(MS_MAX + 1) + 1;
    localparam int POS_W  = LEN_W + 1;

    seq_state_e       st_q, st_n;
    logic [6:0]       dev_q;
    logic [15:0]      mem_q;
    logic [LEN_W-1:0] len_q, idx_q, idx_n;
    logic             rdmode_q;
    logic [POS_W-1:0] pos_q, pos_n;
    logic [4:0]       err_q, err_n;
    logic [MS_W-1:0]  ms;
    logic             wait_exp, post_exp, tmr_clr;
    logic             w_addr, w_last;
    logic [4:0]       drain_code;
    mst_stat_t        stat;
    cmd_word_t        cw;

    eeseq_mstimer #(.TICK_CYC(CLK_KHZ), .MS_W(MS_W)) u_tmr (
        .clk(clk), .rst(rst), .clr(tmr_clr), .ms(ms)
    );

    assign stat = '{abort: mst_abort, addr_nack: mst_addr_nack,
                    data_nack: mst_data_nack, bus_tmo: mst_bus_tmo};

    eeseq_errmap u_emap (.stat(stat), .code(drain_code));

    assign wait_exp = (ms >= MS_W'(WAIT_MS));
    assign post_exp = (ms >= MS_W'(WRCYC_MS));
    assign w_addr   = (pos_q < POS_W'(2));
    assign w_last   = rdmode_q ? (pos_q == POS_W'(1))
                               : (pos_q == {1'b0, len_q} + POS_W'(2));
    assign tmr_clr  = (st_n != st_q);

    always_comb begin
        st_n      = st_q;
        pos_n     = pos_q;
        idx_n     = idx_q;
        err_n     = err_q;
        cw        = '0;
        cmd_valid = 1'b0;
        wr_ready  = 1'b0;
        rd_valid  = 1'b0;
        rx_ready  = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (req_valid) begin
                    st_n  = S_PUSH_W;
                    pos_n = '0;
                    err_n = ERR_OK;
                end
            end
            S_PUSH_W: begin
                cw.stop   = w_last && !rdmode_q;
                cw.data   = (pos_q == '0) ? mem_q[15:8] :
                            (pos_q == POS_W'(1)) ? mem_q[7:0] : wr_data;
                cmd_valid = w_addr ? 1'b1 : wr_valid;
                wr_ready  = !w_addr && cmd_ready;
                if (cmd_valid && cmd_ready) begin
                    if (w_last) st_n = S_DRAIN;
                    else        pos_n = pos_q + 1'b1;
                end else if (wait_exp) begin
                    err_n = ERR_WAIT_TMO;
                    st_n  = S_DONE;
                end
            end
            S_DRAIN: begin
                if (txq_empty) begin
                    if (drain_code != ERR_OK) begin
                        err_n = drain_code;
                        st_n  = S_DONE;
                    end else if (rdmode_q) begin
                        idx_n = '0;
                        st_n  = S_PUSH_R;
                    end else begin
                        st_n  = S_POST;
                    end
                end else if (wait_exp) begin
                    err_n = ERR_WAIT_TMO;
                    st_n  = S_DONE;
                end
            end
            S_PUSH_R: begin
                cmd_valid  = 1'b1;
                cw.rd      = 1'b1;
                cw.restart = (idx_q == '0);
                cw.stop    = (idx_q == len_q);
                if (cmd_ready) begin
                    st_n = S_RX_WAIT;
                end else if (wait_exp) begin
                    err_n = ERR_WAIT_TMO;
                    st_n  = S_DONE;
                end
            end
            S_RX_WAIT: begin
                if (mst_abort && mst_addr_nack) begin
                    err_n = ERR_ADDR_NACK;
                    st_n  = S_DONE;
                end else if (rx_valid) begin
                    rd_valid = 1'b1;
                    rx_ready = rd_ready;
                    if (rd_ready) begin
                        if (idx_q == len_q) begin
                            st_n = S_DONE;
                        end else begin
                            idx_n = idx_q + 1'b1;
                            st_n  = S_PUSH_R;
                        end
                    end
                end else if (wait_exp) begin
                    err_n = ERR_WAIT_TMO;
                    st_n  = S_DONE;
                end
            end
            S_POST: begin
                if (post_exp) st_n = S_DONE;
            end
            S_DONE: st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            pos_q    <= '0;
            idx_q    <= '0;
            err_q    <= ERR_OK;
            dev_q    <= '0;
            mem_q    <= '0;
            len_q    <= '0;
            rdmode_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            pos_q <= pos_n;
            idx_q <= idx_n;
            err_q <= err_n;
            if (st_q == S_IDLE && req_valid) begin
                dev_q    <= req_dev[7:1];
                mem_q    <= req_mem;
                len_q    <= req_len;
                rdmode_q <= req_read;
            end
        end
    end

    assign req_ready   = (st_q == S_IDLE);
    assign cmd_data    = cw.data;
    assign cmd_rd      = cw.rd;
    assign cmd_stop    = cw.stop;
    assign cmd_restart = cw.restart;
    assign tgt_addr    = dev_q;
    assign rd_data     = rx_data;
    assign done        = (st_q == S_DONE);
    assign err         = err_q;

    AST_TGT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> $stable(tgt_addr)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!cmd_valid && !wr_ready && !rd_valid)); // R2
    AST_RESTART_IS_READ: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_restart) |-> cmd_rd); // R4
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready && !mst_abort) |=> (rd_valid && $stable(rd_data))); // R5
    AST_DRAIN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_DRAIN) |-> (ms <= MS_W'(WAIT_MS))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
endmodule

// File: tb/eeprom_seq_bench.sv
module eeprom_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_KHZ    = 4;
    localparam int WAIT_MS    = 20;
    localparam int WRCYC_MS   = 10;
    localparam int LEN_W      = 3;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_read = 0;
    logic [7:0] req_dev = 0;
    logic [15:0] req_mem = 0;
    logic [LEN_W-1:0] req_len = 0;
    logic req_ready, wr_ready, cmd_valid, cmd_rd, cmd_stop, cmd_restart;
    logic wr_valid = 1;
    logic [7:0] wr_data = 0, cmd_data, rx_data = 0, rd_data;
    logic cmd_ready = 1, txq_empty = 1;
    logic mst_abort = 0, mst_addr_nack = 0, mst_data_nack = 0, mst_bus_tmo = 0;
    logic rx_valid = 0, rx_ready, rd_valid, rd_ready = 1, done;
    logic [6:0] tgt_addr;
    logic [4:0] err;

    eeprom_seq #(.CLK_KHZ(CLK_KHZ), .WAIT_MS(WAIT_MS), .WRCYC_MS(WRCYC_MS), .LEN_W(LEN_W)) u_eeprom_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_dev(req_dev), .req_mem(req_mem), .req_len(req_len), .req_read(req_read),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .cmd_rd(cmd_rd), .cmd_stop(cmd_stop), .cmd_restart(cmd_restart),
        .tgt_addr(tgt_addr), .txq_empty(txq_empty), .mst_abort(mst_abort),
        .mst_addr_nack(mst_addr_nack), .mst_data_nack(mst_data_nack),
        .mst_bus_tmo(mst_bus_tmo), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    logic [7:0] lg_d [16];
    logic       lg_rd [16], lg_st [16], lg_rs [16];
    int         lg_cyc [16];
    logic [7:0] rb [16];
    int         rb_cyc [16];
    int n_cmd = 0, n_rd = 0, rx_pend = 0, rx_cnt = 0, wr_idx = 0;
    bit rx_en = 1, rd_slow = 0, done_seen = 0;
    logic [4:0] done_err = 0;
    int done_cyc = 0;

    function automatic logic [7:0] wpat(int i); return 8'(i * 37 + 5); endfunction
    function automatic logic [7:0] rpat(int i); return 8'(i * 53 + 17); endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // I2C master queue and stream partner model
    initial begin
        bit s_cmd, s_rx, s_wr, s_rd;
        logic [7:0] s_cd, s_rdd;
        logic s_cr, s_cs, s_crs;
        forever begin
            @(negedge clk);
            s_cmd = cmd_valid && cmd_ready;
            s_cd = cmd_data; s_cr = cmd_rd; s_cs = cmd_stop; s_crs = cmd_restart;
            s_rx = rx_valid && rx_ready;
            s_wr = wr_valid && wr_ready;
            s_rd = rd_valid && rd_ready;
            s_rdd = rd_data;
            if (done) begin done_seen = 1; done_err = err; done_cyc = cyc; end
            @(posedge clk); #1;
            if (s_cmd && n_cmd < 16) begin
                lg_d[n_cmd] = s_cd; lg_rd[n_cmd] = s_cr; lg_st[n_cmd] = s_cs;
                lg_rs[n_cmd] = s_crs; lg_cyc[n_cmd] = cyc; n_cmd++;
                if (s_cr) rx_pend++;
            end
            if (s_wr) begin wr_idx++; wr_data = wpat(wr_idx); end
            if (s_rd && n_rd < 16) begin rb[n_rd] = s_rdd; rb_cyc[n_rd] = cyc; n_rd++; end
            if (s_rx) rx_valid = 0;
            if (!rx_valid && rx_pend > 0 && rx_en) begin
                rx_valid = 1; rx_data = rpat(rx_cnt); rx_cnt++; rx_pend--;
            end
            rd_ready = rd_slow ? ((cyc % 3) == 0) : 1'b1;
        end
    end

    task automatic send_req(logic [7:0] dev, logic [15:0] mem, int len, bit rd);
        @(negedge clk);
        n_cmd = 0; n_rd = 0; rx_pend = 0; rx_cnt = 0; wr_idx = 0; done_seen = 0;
        wr_data = wpat(0);
        req_dev = dev; req_mem = mem; req_len = LEN_W'(len); req_read = rd; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_done();
        int k = 0;
        while (!done_seen && k < 3000) begin @(negedge clk); #2; k++; end
        if (!done_seen) chk(0, "watchdog", 0, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_abort();
        mst_abort = 0; mst_addr_nack = 0; mst_data_nack = 0; mst_bus_tmo = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready && !cmd_valid && !rd_valid && !done, "R9 reset state",
            {req_ready, cmd_valid, rd_valid, done}, 4'b1000);

        // write sweep over every length
        for (int len = 0; len < 8; len++) begin
            bit ok_ord = 1, ok_flag = 1;
            logic [15:0] mem = 16'(16'h1234 + len * 16'h0111);
            send_req(8'hA0 + 8'(len * 2), mem, len, 0);
            @(negedge clk);
            chk(tgt_addr == 7'((8'hA0 + 8'(len * 2)) >> 1), "R1 target address",
                tgt_addr, (8'hA0 + len * 2) >> 1);
            wait_done();
            chk(n_cmd == len + 3, "R2 write entry count", n_cmd, len + 3);
            for (int i = 0; i < n_cmd && i < 16; i++) begin
                logic [7:0] e;
                e = (i == 0) ? mem[15:8] : (i == 1) ? mem[7:0] : wpat(i - 2);
                if (lg_d[i] !== e) ok_ord = 0;
                if (lg_rd[i] || lg_rs[i] || (lg_st[i] != (i == n_cmd - 1))) ok_flag = 0;
            end
            chk(ok_ord, "R2 write byte order", ok_ord, 1);
            chk(ok_flag, "R2 write flags", ok_flag, 1);
            chk(done_err == 0, "R6 write ok code", done_err, 0);
            chk(done_cyc - lg_cyc[n_cmd-1] >= WRCYC_MS * CLK_KHZ &&
                done_cyc - lg_cyc[n_cmd-1] <= WRCYC_MS * CLK_KHZ + 10,
                "R3 write cycle wait", done_cyc - lg_cyc[n_cmd-1], WRCYC_MS * CLK_KHZ);
        end

        // read sweep, slow consumer on odd lengths
        for (int len = 0; len < 8; len++) begin
            bit ok_a = 1, ok_r = 1, ok_d = 1, ok_o = 1;
            logic [15:0] mem = 16'(16'h0F00 + len);
            rd_slow = len[0];
            send_req(8'hA2, mem, len, 1);
            wait_done();
            chk(n_cmd == len + 3, "R4 read entry count", n_cmd, len + 3);
            if (lg_d[0] !== mem[15:8] || lg_d[1] !== mem[7:0] || lg_rd[0] || lg_rd[1] ||
                lg_st[0] || lg_st[1] || lg_rs[0] || lg_rs[1]) ok_a = 0;
            chk(ok_a, "R4 address phase", ok_a, 1);
            for (int i = 2; i < n_cmd && i < 16; i++) begin
                if (!lg_rd[i] || lg_rs[i] != (i == 2) || lg_st[i] != (i == n_cmd - 1)) ok_r = 0;
                if (i > 2 && lg_cyc[i] <= rb_cyc[i-3]) ok_o = 0;
            end
            chk(ok_r, "R4 read entry flags", ok_r, 1);
            chk(ok_o, "R4 one read outstanding", ok_o, 1);
            chk(n_rd == len + 1, "R5 read byte count", n_rd, len + 1);
            for (int i = 0; i < n_rd && i < 16; i++) if (rb[i] !== rpat(i)) ok_d = 0;
            chk(ok_d, "R5 read byte order", ok_d, 1);
            chk(done_err == 0, "R6 read ok code", done_err, 0);
        end
        rd_slow = 0;

        // abort cause encodings on a write
        for (int m = 0; m < 5; m++) begin
            int exp;
            mst_abort = (m != 4); mst_data_nack = (m == 0 || m == 1 || m == 4);
            mst_addr_nack = (m == 1 || m == 2); mst_bus_tmo = (m == 4);
            exp = (m == 0 || m == 1) ? 2 : (m == 2) ? 1 : (m == 3) ? 16 : 4;
            send_req(8'hA0, 16'h0010, 1, 0);
            wait_done();
            clear_abort();
            chk(done_err == 5'(exp), "R6 abort code", done_err, exp);
            chk(done_cyc - lg_cyc[n_cmd-1] < 10, "R8 no write wait after failure",
                done_cyc - lg_cyc[n_cmd-1], 2);
        end
        mst_abort = 1; mst_data_nack = 1; mst_bus_tmo = 1;
        send_req(8'hA0, 16'h0020, 0, 0);
        wait_done();
        clear_abort();
        chk(done_err == 5'h06, "R6 combined flags", done_err, 6);

        // address-phase failure skips the read
        mst_abort = 1; mst_addr_nack = 1;
        send_req(8'hA4, 16'h0100, 3, 1);
        wait_done();
        clear_abort();
        chk(done_err == 5'h01, "R8 address phase code", done_err, 1);
        chk(n_cmd == 2 && n_rd == 0, "R8 read skipped", n_cmd, 2);

        // queue never drains
        txq_empty = 0;
        send_req(8'hA0, 16'h0200, 1, 0);
        wait_done();
        txq_empty = 1;
        chk(done_err == 5'h08, "R7 drain timeout code", done_err, 8);
        chk(done_cyc - lg_cyc[n_cmd-1] >= WAIT_MS * CLK_KHZ &&
            done_cyc - lg_cyc[n_cmd-1] <= WAIT_MS * CLK_KHZ + 10,
            "R7 drain timeout window", done_cyc - lg_cyc[n_cmd-1], WAIT_MS * CLK_KHZ);

        // queue refuses entries
        cmd_ready = 0;
        send_req(8'hA0, 16'h0300, 2, 0);
        wait_done();
        cmd_ready = 1;
        chk(done_err == 5'h08 && n_cmd == 0, "R7 push stall timeout", done_err, 8);

        // receive data never arrives
        rx_en = 0;
        send_req(8'hA0, 16'h0400, 2, 1);
        wait_done();
        chk(done_err == 5'h08, "R7 receive timeout code", done_err, 8);
        chk(n_cmd == 3 && n_rd == 0, "R7 receive timeout stops reads", n_cmd, 3);

        // address NACK while waiting for a byte
        send_req(8'hA0, 16'h0500, 2, 1);
        begin
            int k = 0;
            while (n_cmd < 3 && k < 500) begin @(negedge clk); k++; end
        end
        mst_abort = 1; mst_addr_nack = 1;
        wait_done();
        clear_abort();
        rx_en = 1;
        chk(done_err == 5'h01, "R10 mid-read address nack", done_err, 1);
        chk(n_rd == 0 && n_cmd == 3, "R10 no byte delivered", n_rd, 0);

        @(negedge clk);
        chk(req_ready && !done, "R9 idle after sequences", req_ready, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule